// File: doc/BRIEF.md
# I2C Bus Recovery Sequence Generator

This block takes over the two wires of an I2C bus for a short time and plays a fixed pattern that puts a serial EEPROM back into a known, idle state. It is used when the EEPROM may be stuck in the middle of a transfer. This can happen after the host controller was reset during a transfer, or after noise on the lines. A one-cycle request on `start_i` launches the pattern. `busy_o` stays high while it plays, and `done_o` pulses once when the bus has been handed back.

The pattern has four parts:

- A START condition.
- A run of clock pulses with SDA left released. A slave that was driving an acknowledge or a low data bit therefore reads a not-acknowledge and lets go of SDA.
- A second START.
- A STOP.

The second START comes before the STOP. Because of this, a slave that was receiving a write command cannot take the STOP as the order to begin a programming cycle. The final STOP leaves the slave in standby and the bus idle.

Both wires are open-drain. Each output only asks for its line to be pulled low (1) or released (0), and never drives a line high. Timing uses a quarter of a bit period as its unit. That unit is `QTR_CYCLES` clock cycles long. Every SCL low phase and every SCL high phase of the released-data pulses lasts two quarters.

The pins are plain control pins with no streaming data. Detecting the need for recovery and arbitrating with another master are left to the surrounding logic.

Top module: `busclr_gen`

## Requirements
- R1: After reset, and whenever no sequence is running, both pull outputs are 0 (lines released), and `busy_o` and `done_o` are 0.
- R2: A 1 on `start_i` sampled at a rising edge while idle starts a sequence. `busy_o` is 1 from that edge for exactly (9 + 4·`NUM_ONES`)·`QTR_CYCLES` cycles.
- R3: The first four quarters, given as (SCL, SDA) with 1 = released, are (1,1), (1,0), (0,0), (0,1). The START is the SDA fall while SCL is released.
- R4: Next come `NUM_ONES` pulses, 9 by default. Each pulse is SCL held low for two quarters and then released for two quarters, with SDA released throughout.
- R5: Right after the last pulse, a repeated START follows: one quarter of (1,0), then one quarter of (0,0).
- R6: The sequence ends with a STOP of three quarters: (0,0), (1,0), (1,1).
- R7: Each quarter lasts exactly `QTR_CYCLES` clock cycles. The line outputs show the quarter of the previous cycle's state, so quarter k is visible during cycles k·Q+1 to (k+1)·Q after the accepting edge.
- R8: `done_o` is 1 for exactly one cycle, namely the first cycle in which `busy_o` is back to 0. From the next cycle on, both lines are released.
- R9: A 1 on `start_i` while a sequence is running is ignored. The waveform, its length and the end time do not change.
- R10: A line is pulled low only while a sequence runs, or in the single cycle just after it ends. Otherwise it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to launch the recovery pattern |
| scl_pull_o | output | 1 | 1 = pull SCL low, 0 = release SCL |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release SDA |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse once the bus is handed back |

## Verification
The hardest case to reach from the ports is a request that lands while the pattern runs, and especially one on the very last busy cycle, where a wrong acceptance would silently chain a second sequence. The stimulus raises `start_i` at random points inside running sequences. A directed case places a request exactly on the final STOP cycle. The bench then checks every cycle of the waveform and the busy and done timing against a model built from the quarter table.

// File: rtl/busclr_pkg.sv
package busclr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_ONES,
    PH_REST,
    PH_STOP
  } phase_e;

  // 1 = line released, 0 = line pulled low
  typedef struct packed {
    logic scl_rel;
    logic sda_rel;
  } lines_t;

  localparam lines_t LINES_FREE = '{scl_rel: 1'b1, sda_rel: 1'b1};

endpackage

// File: rtl/busclr_qtick.sv
module busclr_qtick #(
  parameter int QTR_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (QTR_CYCLES <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int DIV_W = $clog2(QTR_CYCLES);
      localparam logic [DIV_W-1:0] CNT_LAST = DIV_W'(QTR_CYCLES - 1);

      logic [DIV_W-1:0] cnt;

      assign tick = run && (cnt == CNT_LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (!run || tick) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      // R9: a running quarter keeps counting; nothing restarts it mid-way
      p_quarter_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt == DIV_W'($past(cnt) + 1'b1)));

      // R7: the counter never passes the quarter length
      p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= CNT_LAST));
    end
  endgenerate

endmodule

// File: rtl/busclr_seq.sv
module busclr_seq
  import busclr_pkg::*;
#(
  parameter int NUM_ONES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       tick,
  output phase_e     phase,
  output logic [1:0] qidx,
  output logic       busy,
  output logic       done
);

  localparam int BIT_W = (NUM_ONES > 1) ? $clog2(NUM_ONES) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(NUM_ONES - 1);

  logic [BIT_W-1:0] bitc;
  logic             phase_last;
  phase_e           phase_next;

  assign busy = (phase != PH_IDLE);

  always_comb begin
    phase_last = 1'b0;
    phase_next = phase;
    case (phase)
      PH_LEAD: begin
        phase_last = (qidx == 2'd3);
        phase_next = PH_ONES;
      end
      PH_ONES: begin
        phase_last = (qidx == 2'd3) && (bitc == BIT_LAST);
        phase_next = PH_REST;
      end
      PH_REST: begin
        phase_last = (qidx == 2'd1);
        phase_next = PH_STOP;
      end
      PH_STOP: begin
        phase_last = (qidx == 2'd2);
        phase_next = PH_IDLE;
      end
      default: begin
        phase_last = 1'b0;
        phase_next = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      qidx  <= '0;
      bitc  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start_i) begin
          phase <= PH_LEAD;
          qidx  <= '0;
          bitc  <= '0;
        end
      end else if (tick) begin
        if (phase_last) begin
          phase <= phase_next;
          qidx  <= '0;
          bitc  <= '0;
          done  <= (phase_next == PH_IDLE);
        end else begin
          qidx <= qidx + 1'b1;
          if (phase == PH_ONES && qidx == 2'd3) begin
            bitc <= bitc + 1'b1;
          end
        end
      end
    end
  end

  // R2: a request while idle opens the lead-in at its first quarter
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && start_i) |=> (phase == PH_LEAD && qidx == 2'd0));

  // R9: while running, nothing but a quarter tick moves the state
  p_ignore_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> (phase == $past(phase) && qidx == $past(qidx)));

  // R4: the pulse counter stays inside the configured run
  p_pulse_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ONES) |-> (bitc <= BIT_LAST));

  // R8: completion is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/busclr_lines.sv
module busclr_lines
  import busclr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_e     phase,
  input  logic [1:0] qidx,
  output lines_t     lines_q
);

  lines_t lines_d;

  always_comb begin
    lines_d = LINES_FREE;
    case (phase)
      PH_LEAD: begin
        case (qidx)
          2'd0:    lines_d = '{scl_rel: 1'b1, sda_rel: 1'b1};
          2'd1:    lines_d = '{scl_rel: 1'b1, sda_rel: 1'b0};
          2'd2:    lines_d = '{scl_rel: 1'b0, sda_rel: 1'b0};
          default: lines_d = '{scl_rel: 1'b0, sda_rel: 1'b1};
        endcase
      end
      PH_ONES: begin
        lines_d = '{scl_rel: qidx[1], sda_rel: 1'b1};
      end
      PH_REST: begin
        lines_d = '{scl_rel: (qidx == 2'd0), sda_rel: 1'b0};
      end
      PH_STOP: begin
        case (qidx)
          2'd0:    lines_d = '{scl_rel: 1'b0, sda_rel: 1'b0};
          2'd1:    lines_d = '{scl_rel: 1'b1, sda_rel: 1'b0};
          default: lines_d = '{scl_rel: 1'b1, sda_rel: 1'b1};
        endcase
      end
      default: lines_d = LINES_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= LINES_FREE;
    end else begin
      lines_q <= lines_d;
    end
  end

  // R4: data line stays released for every pulse of the run
  p_ones_sda_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ONES) |=> lines_q.sda_rel);

  // R1: an idle sequencer leaves both lines released
  p_idle_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |=> (lines_q == LINES_FREE));

  // R6: the last stop quarter releases both lines
  p_stop_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STOP && qidx == 2'd2) |=> (lines_q == LINES_FREE));

endmodule

// File: rtl/busclr_gen.sv
module busclr_gen
  import busclr_pkg::*;
#(
  parameter int QTR_CYCLES = 4,
  parameter int NUM_ONES   = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o,
  output logic done_o
);

  phase_e     phase;
  logic [1:0] qidx;
  logic       busy;
  logic       done;
  logic       tick;
  lines_t     lines_q;

  busclr_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_qtick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  busclr_seq #(.NUM_ONES(NUM_ONES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .tick   (tick),
    .phase  (phase),
    .qidx   (qidx),
    .busy   (busy),
    .done   (done)
  );

  busclr_lines u_lines (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .qidx   (qidx),
    .lines_q(lines_q)
  );

  assign scl_pull_o = ~lines_q.scl_rel;
  assign sda_pull_o = ~lines_q.sda_rel;
  assign busy_o     = busy;
  assign done_o     = done;

  // R8: completion is flagged in the first cycle after busy drops
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R10: a line is pulled only during, or just after, a running sequence
  p_pull_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull_o || sda_pull_o) |-> $past(busy_o));

endmodule

// File: tb/test_busclr_gen.sv
module test_busclr_gen;

  localparam int QTR  = 4;
  localparam int ONES = 9;
  localparam int TOTQ = 9 + 4 * ONES;
  localparam int SEQ  = TOTQ * QTR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic scl_pull, sda_pull, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  busclr_gen #(.QTR_CYCLES(QTR), .NUM_ONES(ONES)) i_busclr_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .scl_pull_o(scl_pull),
    .sda_pull_o(sda_pull),
    .busy_o    (busy),
    .done_o    (done)
  );

  // {scl_rel, sda_rel} expected for quarter k of the pattern
  function automatic logic [1:0] exp_rel(int k);
    int r;
    if (k < 4) begin                    // R3 lead-in START
      case (k)
        0: return 2'b11;
        1: return 2'b10;
        2: return 2'b00;
        default: return 2'b01;
      endcase
    end else if (k < 4 + 4 * ONES) begin // R4 released-data pulses
      return (((k - 4) % 4) < 2) ? 2'b01 : 2'b11;
    end
    r = k - 4 - 4 * ONES;
    case (r)
      0: return 2'b10;                  // R5 repeated START
      1: return 2'b00;
      2: return 2'b00;                  // R6 STOP
      3: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic string tag_of(int k);
    if (k < 4) return "R3";
    if (k < 4 + 4 * ONES) return "R4";
    if (k < 6 + 4 * ONES) return "R5";
    return "R6";
  endfunction

  // obs/exp layout: {scl_pull, sda_pull, busy, done}
  task automatic chk(string tag, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // mode 0: clean, 1: random requests while busy, 2: request on last busy cycle
  task automatic run_seq(int mode);
    logic [1:0] rel;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "accept", {scl_pull, sda_pull, busy, done}, 4'b0010);
    for (int c = 1; c <= SEQ + 1; c++) begin
      @(negedge clk);
      if (c <= SEQ) begin
        // R7: quarter k visible for cycles k*Q+1 .. (k+1)*Q
        rel = exp_rel((c - 1) / QTR);
        chk(tag_of((c - 1) / QTR), "line", {scl_pull, sda_pull, busy, done},
            {~rel, (c < SEQ), (c == SEQ)});
      end else begin
        chk("R8", "released after done", {scl_pull, sda_pull, busy, done}, 4'b0000);
      end
      if (mode == 1 && c < SEQ) start = (($urandom % 4) == 0); // R9
      else if (mode == 2 && c == SEQ - 1) start = 1'b1;        // R9 corner
      else start = 1'b0;
    end
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset state", {scl_pull, sda_pull, busy, done}, 4'b0000);
    run_seq(0);
    run_seq(2);
    for (int i = 0; i < 5; i++) begin
      int gap;
      gap = 1 + ($urandom % 7);
      repeat (gap) @(negedge clk);
      chk("R1", "idle gap", {scl_pull, sda_pull, busy, done}, 4'b0000);
      run_seq(1);
    end
    repeat (4) @(negedge clk);
    chk("R10", "final idle", {scl_pull, sda_pull, busy, done}, 4'b0000);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule